// File: doc/BRIEF.md
# Configurable Multiplexer Logic Cell

This block is a fine-grained programmable logic cell. Its core is a 4-to-1 multiplexer whose two select bits are not wired directly to pins: the low select is the AND of two inputs and the high select is the OR of two other inputs. With four data inputs and four select-term inputs, the cell computes one fixed function of eight inputs. The data input picked for each select value is D00 for 00, D01 for 01, D10 for 10 and D11 for 11, written {S1,S0}.

The cell comes in two build variants, chosen by the parameter `SEQ_VARIANT`. The combinational variant (`SEQ_VARIANT = 0`) sends the multiplexer result straight to the output and ignores the clock/gate, clear and configuration pins. The sequential variant (`SEQ_VARIANT = 1`) places a storage element after the multiplexer. A static 2-bit configuration field puts that element in one of three operating states. In BYPASS, the output is the combinational result. In FLOP, the element is a rising-edge D flip-flop. In LATCH, the element is a latch that is transparent while the gate is high. The element moves from one state to another only when the configuration field is rewritten: 00 goes to BYPASS, 01 to FLOP, 10 to LATCH, and the reserved code 11 falls back to BYPASS. The clear input is active high and asynchronous. It acts on the flip-flop and on the latch.

Top module: `mux_logic_cell`

## Requirements
- R1: The low select bit S0 is 1 exactly when both `a0` and `b0` are 1.
- R2: The high select bit S1 is 1 when `a1` or `b1` (or both) is 1.
- R3: With `cfg_mode` = 2'b00 (BYPASS), `cell_out` equals D00, D01, D10 or D11 for {S1,S0} = 00, 01, 10 or 11 respectively, for all 256 combinations of the eight inputs.
- R4: The reserved code `cfg_mode` = 2'b11 gives the same output as BYPASS for all 256 input combinations.
- R5: With `cfg_mode` = 2'b01 (FLOP) and `clr` low, `cell_out` takes the multiplexer result present at each rising edge of `clk_gate`, and holds that value between edges while the inputs change.
- R6: With `cfg_mode` = 2'b10 (LATCH), `clr` low and `clk_gate` high, `cell_out` follows the multiplexer result.
- R7: With `cfg_mode` = 2'b10 and `clk_gate` low, `cell_out` holds the value it had when the gate fell, whatever the data and select inputs do.
- R8: In FLOP and LATCH, a high `clr` forces `cell_out` to 0 at once, without waiting for a clock edge. It wins over rising clock edges and over an open gate.
- R9: In BYPASS, `clr` has no effect: `cell_out` still equals the multiplexer result.
- R10: A cell built with `SEQ_VARIANT` = 0 always drives the multiplexer result, whatever `cfg_mode`, `clr` and `clk_gate` are doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_gate | input | 1 | Rising-edge clock in FLOP; transparency enable (high = open) in LATCH |
| clr | input | 1 | Asynchronous active-high clear of the storage element |
| cfg_mode | input | 2 | Static storage configuration: 00 bypass, 01 flip-flop, 10 latch, 11 bypass |
| a0 | input | 1 | Low select term, first AND input |
| b0 | input | 1 | Low select term, second AND input |
| a1 | input | 1 | High select term, first OR input |
| b1 | input | 1 | High select term, second OR input |
| d00 | input | 1 | Data input chosen when {S1,S0} = 00 |
| d01 | input | 1 | Data input chosen when {S1,S0} = 01 |
| d10 | input | 1 | Data input chosen when {S1,S0} = 10 |
| d11 | input | 1 | Data input chosen when {S1,S0} = 11 |
| cell_out | output | 1 | Cell output |

## Verification
At every falling edge of `clk_gate`, the checker compares the output against a reference:
- In FLOP, against the value captured at the last rising edge or by clear.
- In LATCH, against the live multiplexer result at the moment the gate closes.
- In BYPASS or reserved mode, against the live multiplexer result.
- While clear is high in a storing mode, against zero.

Some behaviours are visible only through the bench's directed scenarios:
- The full 256-entry truth table with no clock activity.
- A latch that keeps its value while its inputs move with the gate low.
- An output that drops the moment clear rises in the middle of a clock phase.
- A combinational build that ignores every control pin.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

    // Multiplexer geometry: two select bits choose among four data inputs.
    localparam int MUX_SEL_W  = 2;
    localparam int MUX_DATA_N = 1 << MUX_SEL_W;

    // Static configuration codes of the storage element.
    typedef enum logic [1:0] {
        CFG_BYPASS = 2'b00,
        CFG_FLOP   = 2'b01,
        CFG_LATCH  = 2'b10,
        CFG_RSVD   = 2'b11
    } cell_cfg_e;

    // Which source drives the cell output.
    typedef enum logic [1:0] {
        OSEL_COMB,
        OSEL_FLOP,
        OSEL_LATCH
    } out_sel_e;

    // Map a configuration code to an output source; reserved falls back to bypass.
    function automatic out_sel_e decode_cfg(input logic [1:0] code);
        out_sel_e r;
        unique case (code)
            CFG_FLOP:  r = OSEL_FLOP;
            CFG_LATCH: r = OSEL_LATCH;
            CFG_RSVD:  r = OSEL_COMB;
            default:   r = OSEL_COMB;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mlc_select.sv
module mlc_select
    import mlc_pkg::*;
(
    input  logic                 a0,
    input  logic                 b0,
    input  logic                 a1,
    input  logic                 b1,
    output logic [MUX_SEL_W-1:0] sel
);

    logic sel_and;
    logic sel_or;

    // Low select bit is a product term, high select bit a sum term.
    always_comb begin
        sel_and = a0 & b0;
        sel_or  = a1 | b1;
        sel     = {sel_or, sel_and};
    end

endmodule

// File: rtl/mlc_mux4.sv
module mlc_mux4
    import mlc_pkg::*;
(
    input  logic [MUX_SEL_W-1:0]  sel,
    input  logic [MUX_DATA_N-1:0] din,
    output logic                  y
);

    always_comb begin
        unique case (sel)
            2'b00:   y = din[0];
            2'b01:   y = din[1];
            2'b10:   y = din[2];
            2'b11:   y = din[3];
            default: y = 1'b0;
        endcase
    end

endmodule

// File: rtl/mlc_store.sv
module mlc_store
    import mlc_pkg::*;
(
    input  logic       clk_gate,
    input  logic       clr,
    input  logic [1:0] cfg_mode,
    input  logic       y,
    output logic       q
);

    logic     q_flop;
    logic     q_latch;
    out_sel_e out_sel;

    // Edge-triggered element with asynchronous clear.
    always_ff @(posedge clk_gate or posedge clr) begin
        if (clr) begin
            q_flop <= 1'b0;
        end else begin
            q_flop <= y;
        end
    end

    // Level-sensitive element, open while the gate is high; clear wins.
    always_latch begin
        if (clr) begin
            q_latch = 1'b0;
        end else if (clk_gate) begin
            q_latch = y;
        end
    end

    assign out_sel = decode_cfg(cfg_mode);

    always_comb begin
        unique case (out_sel)
            OSEL_FLOP:  q = q_flop;
            OSEL_LATCH: q = q_latch;
            OSEL_COMB:  q = y;
            default:    q = y;
        endcase
    end

endmodule

// File: rtl/mux_logic_cell.sv
module mux_logic_cell
    import mlc_pkg::*;
#(
    parameter bit SEQ_VARIANT = 1'b1
) (
    input  logic       clk_gate,
    input  logic       clr,
    input  logic [1:0] cfg_mode,
    input  logic       a0,
    input  logic       b0,
    input  logic       a1,
    input  logic       b1,
    input  logic       d00,
    input  logic       d01,
    input  logic       d10,
    input  logic       d11,
    output logic       cell_out
);

    logic [MUX_SEL_W-1:0]  sel;
    logic [MUX_DATA_N-1:0] din;
    logic                  mux_y;

    assign din = {d11, d10, d01, d00};

    mlc_select u_select (
        .a0  (a0),
        .b0  (b0),
        .a1  (a1),
        .b1  (b1),
        .sel (sel)
    );

    mlc_mux4 u_mux (
        .sel (sel),
        .din (din),
        .y   (mux_y)
    );

    generate
        if (SEQ_VARIANT) begin : g_seq
            mlc_store u_store (
                .clk_gate (clk_gate),
                .clr      (clr),
                .cfg_mode (cfg_mode),
                .y        (mux_y),
                .q        (cell_out)
            );
        end else begin : g_comb
            logic unused_ctrl;
            assign unused_ctrl = ^{clk_gate, clr, cfg_mode};
            assign cell_out    = mux_y;
        end
    endgenerate

endmodule

// File: rtl/mux_logic_cell_chk.sv
module mux_logic_cell_chk #(
    parameter bit SEQ_VARIANT = 1'b1
) (
    input logic       clk_gate,
    input logic       clr,
    input logic [1:0] cfg_mode,
    input logic       a0,
    input logic       b0,
    input logic       a1,
    input logic       b1,
    input logic       d00,
    input logic       d01,
    input logic       d10,
    input logic       d11,
    input logic       cell_out
);

    logic       ref_y;
    logic [1:0] eff_mode;
    logic       exp_q;
    logic       exp_valid = 1'b0;

    // Reference result from the pins, written as nested selection.
    assign ref_y    = (a1 || b1) ? ((a0 && b0) ? d11 : d10)
                                 : ((a0 && b0) ? d01 : d00);
    assign eff_mode = SEQ_VARIANT ? cfg_mode : 2'b00;

    // Expected content of the edge-triggered element.
    always_ff @(posedge clk_gate or posedge clr) begin
        if (clr) begin
            exp_q     <= 1'b0;
            exp_valid <= 1'b1;
        end else begin
            exp_q     <= ref_y;
            exp_valid <= 1'b1;
        end
    end

    always @(negedge clk_gate) begin
        // R5
        ff_capture_chk: assert (!(eff_mode == 2'b01 && exp_valid) || cell_out == exp_q)
            else $error("ff_capture_chk: out %b expected %b", cell_out, exp_q);
        // R8
        clear_chk: assert (!(clr && (eff_mode == 2'b01 || eff_mode == 2'b10)) || cell_out == 1'b0)
            else $error("clear_chk: out %b while clear high", cell_out);
        // R3 R4 R9 R10
        bypass_chk: assert (!(eff_mode[1] == eff_mode[0]) || cell_out == ref_y)
            else $error("bypass_chk: out %b expected %b", cell_out, ref_y);
        // R6
        latch_close_chk: assert (!(eff_mode == 2'b10 && !clr) || cell_out == ref_y)
            else $error("latch_close_chk: out %b expected %b", cell_out, ref_y);
    end

endmodule

bind mux_logic_cell mux_logic_cell_chk #(.SEQ_VARIANT(SEQ_VARIANT)) u_chk (.*);

// File: tb/mux_logic_cell_tb.sv
`timescale 1ns/1ps
module mux_logic_cell_tb;

    logic       ref_clk = 1'b0;
    logic       clk_gate = 1'b0;
    logic       clr = 1'b1;
    logic [1:0] cfg_mode = 2'b01;
    logic [7:0] vec = 8'h00;   // bit0 a0, 1 b0, 2 a1, 3 b1, 4 d00, 5 d01, 6 d10, 7 d11
    logic       out_seq;
    logic       out_comb;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 ref_clk = ~ref_clk;   // 250 MHz reference

    mux_logic_cell #(.SEQ_VARIANT(1'b1)) u_dut (
        .clk_gate (clk_gate), .clr (clr), .cfg_mode (cfg_mode),
        .a0 (vec[0]), .b0 (vec[1]), .a1 (vec[2]), .b1 (vec[3]),
        .d00 (vec[4]), .d01 (vec[5]), .d10 (vec[6]), .d11 (vec[7]),
        .cell_out (out_seq)
    );

    mux_logic_cell #(.SEQ_VARIANT(1'b0)) u_dut_comb (
        .clk_gate (clk_gate), .clr (clr), .cfg_mode (cfg_mode),
        .a0 (vec[0]), .b0 (vec[1]), .a1 (vec[2]), .b1 (vec[3]),
        .d00 (vec[4]), .d01 (vec[5]), .d10 (vec[6]), .d11 (vec[7]),
        .cell_out (out_comb)
    );

    function automatic logic model(input logic [7:0] v);
        logic s0;
        logic s1;
        s0 = v[0] & v[1];
        s1 = v[2] | v[3];
        return v[4 + {30'd0, s1, s0}];
    endfunction

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic apply(input logic [7:0] v);
        vec = v;
        #1;
    endtask

    task automatic pulse;
        #1 clk_gate = 1'b1;
        #2 clk_gate = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        #2;
        check(out_seq, 1'b0, "R8", "clear at start, flop mode");
        cfg_mode = 2'b10;
        #1;
        check(out_seq, 1'b0, "R8", "clear at start, latch mode");
        clr = 1'b0;
        cfg_mode = 2'b00;
        #1;
    endtask

    task automatic t_select_terms;
        // R1: d01=1 only, a1=b1=0, so out = a0 AND b0
        for (int i = 0; i < 4; i++) begin
            apply({4'b0010, 2'b00, i[1:0]});
            check(out_seq, i[0] & i[1], "R1", $sformatf("a0b0=%b%b", i[0], i[1]));
        end
        // R2: d10=1 only, a0=b0=0, so out = a1 OR b1
        for (int i = 0; i < 4; i++) begin
            apply({4'b0100, i[1:0], 2'b00});
            check(out_seq, i[0] | i[1], "R2", $sformatf("a1b1=%b%b", i[0], i[1]));
        end
    endtask

    task automatic t_exhaustive(input logic [1:0] code, input string req);
        cfg_mode = code;
        for (int i = 0; i < 256; i++) begin
            apply(i[7:0]);
            check(out_seq, model(i[7:0]), req, $sformatf("cfg %b vec %02h", code, i[7:0]));
        end
    endtask

    task automatic t_flop;
        cfg_mode = 2'b01;
        clr = 1'b0;
        for (int i = 0; i < 8; i++) begin
            logic [7:0] v;
            v = 8'h35 * i[7:0] + 8'h1b;
            apply(v);
            pulse();
            check(out_seq, model(v), "R5", $sformatf("capture %02h", v));
            apply(~v);
            apply(v ^ 8'hf0);
            check(out_seq, model(v), "R5", $sformatf("hold after %02h", v));
        end
    endtask

    task automatic t_latch;
        cfg_mode = 2'b10;
        clr = 1'b0;
        #1 clk_gate = 1'b1;
        for (int i = 0; i < 16; i++) begin
            apply(i[7:0] * 8'h17);
            check(out_seq, model(i[7:0] * 8'h17), "R6", "transparent follow");
        end
        apply(8'h10);               // d00=1 selected -> 1
        check(out_seq, 1'b1, "R6", "transparent value before close");
        clk_gate = 1'b0;
        #1;
        apply(8'h00);
        check(out_seq, 1'b1, "R7", "hold with selected data now 0");
        apply(8'h2f);
        check(out_seq, 1'b1, "R7", "hold with selects moved");
        #1 clk_gate = 1'b1;
        apply(8'h00);
        clk_gate = 1'b0;
        #1;
        apply(8'hf0);
        check(out_seq, 1'b0, "R7", "hold of 0 with all data 1");
    endtask

    task automatic t_clear;
        cfg_mode = 2'b01;
        clr = 1'b0;
        apply(8'h10);
        pulse();
        check(out_seq, 1'b1, "R8", "flop preloaded to 1");
        #1 clr = 1'b1;
        #1;
        check(out_seq, 1'b0, "R8", "async clear in flop mode");
        pulse();
        check(out_seq, 1'b0, "R8", "clear wins over rising edge");
        clr = 1'b0;
        #1;
        check(out_seq, 1'b0, "R8", "flop stays 0 after clear release");
        cfg_mode = 2'b10;
        #1 clk_gate = 1'b1;
        apply(8'h10);
        check(out_seq, 1'b1, "R8", "latch open shows 1");
        clr = 1'b1;
        #1;
        check(out_seq, 1'b0, "R8", "clear wins over open gate");
        clr = 1'b0;
        #1;
        check(out_seq, 1'b1, "R8", "latch follows after release");
        clk_gate = 1'b0;
        #1;
    endtask

    task automatic t_clr_bypass;
        cfg_mode = 2'b00;
        clr = 1'b1;
        for (int i = 0; i < 8; i++) begin
            apply(8'h91 + i[7:0] * 8'h0d);
            pulse();
            check(out_seq, model(8'h91 + i[7:0] * 8'h0d), "R9", "clear ignored in bypass");
        end
        clr = 1'b0;
    endtask

    task automatic t_comb_variant;
        for (int i = 0; i < 16; i++) begin
            logic [7:0] v;
            v = 8'h5a ^ (i[7:0] * 8'h23);
            cfg_mode = i[1:0];
            clr = i[2];
            apply(v);
            pulse();
            apply(v);
            check(out_comb, model(v), "R10", $sformatf("comb build cfg %b clr %b", i[1:0], i[2]));
        end
        clr = 1'b0;
    endtask

    initial begin
        t_reset();
        t_select_terms();
        t_exhaustive(2'b00, "R3");
        t_exhaustive(2'b11, "R4");
        t_flop();
        t_latch();
        t_clear();
        t_clr_bypass();
        t_comb_variant();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge ref_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule